// File: doc/BRIEF.md
# Age-Ordered Transaction Conflict Resolver

This unit sits beside one core of an eager hardware transactional memory. When a coherence request from another core collides with the transaction running here, the conflict reaches the unit straight away, at request time and not at commit. The unit then gives one of two verdicts. Either the requester is refused (a NACK, so the requester stalls and retries), or the local transaction gives way and is told to abort. Which of the two it picks depends on a policy select that travels with each conflict. There are three policies: always stall, strict age order, and a mix of the two that lets an older writer evict a younger reader.

The age of the local transaction is a timestamp. It is copied from a shared cycle counter on the first begin of a transaction and held through every abort and retry until commit, so a transaction that keeps losing grows relatively older and in the end wins. The same unit also watches the core's own outgoing requests. If this transaction has refused an older requester and is then itself refused by an older responder, a cycle of waiting may have formed, and the unit aborts the local transaction.

Conflicts enter on a valid/ready channel, and each verdict leaves on a one-entry valid/ready channel. A conflict is taken on any cycle where the output slot is empty or is being drained in the same cycle. While a verdict is waiting with `resp_ready` low, it is held unchanged and no new conflict is taken.

Top module: `txn_conflict_resolver`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `resp_valid`, `abort_req` and `stall_retry` are low.
- R2: `txn_begin` stores `gtime` as the local timestamp only when no timestamp is held. A later `txn_begin` leaves the stored value unchanged. `txn_commit` releases the timestamp, and if both arrive in the same cycle, commit wins.
- R3: A requester is older when its timestamp is smaller than the local one. On equal timestamps, the smaller core identifier counts as older.
- R4: Under policy 0 (and the spare code 3), every conflict with a held transaction gives a NACK and never a local abort. A verdict never carries both a NACK and an abort.
- R5: Under policy 1, an older requester makes the local transaction abort with no NACK. A younger requester is NACKed.
- R6: Under policy 2, a conflict of type 0 (the requester writes a line the local transaction read) with an older requester aborts the local transaction. Every other case is NACKed.
- R7: A NACK carries `resp_meta` made of a one-hot conflict type in bits 2:0 (bit 0 for type 0, bit 1 for type 1 where the requester reads a line written locally, bit 2 for type 2 where both write, with type code 3 also counted as bit 2) and, in bit 3, a 1 when the local transaction is older. A verdict without a NACK has `resp_meta` all zero.
- R8: When no timestamp is held, a conflict is granted: no NACK, no abort, zero metadata.
- R9: When the core's own request is NACKed (`own_req_nacked`) by an older responder after this transaction NACKed an older requester, `abort_req` pulses on the next cycle and `stall_retry` does not. Any other own NACK gives a one-cycle `stall_retry` pulse, unless an abort is raised in that same cycle. The two pulses are never high together.
- R10: `conf_ready` is high exactly when `resp_valid` is low or `resp_ready` is high. A pending verdict stays stable until it is taken.
- R11: A verdict with `resp_abort` appears together with a one-cycle `abort_req` pulse, on the cycle after the conflict is accepted.
- R12: The record of having NACKed an older requester is cleared by any `abort_req`, by `txn_commit` and by `txn_begin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gtime | input | TS_W | Shared cycle counter value |
| txn_begin | input | 1 | Transaction begin (first or retry) |
| txn_commit | input | 1 | Transaction committed |
| conf_valid | input | 1 | Conflict presented |
| conf_ready | output | 1 | Conflict can be accepted |
| conf_policy | input | 2 | Policy: 0 stall, 1 age order, 2 mixed, 3 as 0 |
| conf_type | input | 2 | 0 requester writes/local read, 1 requester reads/local wrote, 2 both write, 3 as 2 |
| conf_req_ts | input | TS_W | Requester timestamp |
| conf_req_id | input | ID_W | Requester core identifier |
| resp_valid | output | 1 | Verdict available |
| resp_ready | input | 1 | Verdict consumer ready |
| resp_nack | output | 1 | Requester is refused |
| resp_abort | output | 1 | Local transaction yields |
| resp_meta | output | 4 | NACK metadata: bits 2:0 type, bit 3 local older |
| own_req_nacked | input | 1 | Own outgoing request was NACKed |
| own_nack_resp_older | input | 1 | Older bit from that incoming NACK |
| abort_req | output | 1 | Abort the local transaction (pulse) |
| stall_retry | output | 1 | Stall and retry own request (pulse) |

## Verification
The bench builds the unit with an 8-bit timestamp, a 3-bit core identifier and a local identifier of 3. With these values, small hand-picked timestamps cover older, younger and tied requesters, and identifiers 2 and 5 fall on either side of the local one in a tie. The global time fed at begin is varied, and a second begin is issued, to show that the age is captured once and released only on commit. The deadlock sequence is driven with the older bit both set and clear, and it is repeated after commit, so every path into and out of the refused-older record is reached.

// File: rtl/txcr_pkg.sv
package txcr_pkg;
  typedef enum logic [1:0] {
    POL_STALL   = 2'd0,
    POL_AGE     = 2'd1,
    POL_MIXED   = 2'd2,
    POL_SPARE   = 2'd3
  } policy_e;

  typedef enum logic [1:0] {
    CT_WAR      = 2'd0,
    CT_RAW      = 2'd1,
    CT_WAW      = 2'd2,
    CT_WAW_ALT  = 2'd3
  } ctype_e;

  localparam int META_W = 4;

  typedef struct packed {
    logic              nack;
    logic              abort;
    logic [META_W-1:0] meta;
  } verdict_t;
endpackage

// File: rtl/txcr_ts_holder.sv
module txcr_ts_holder #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] gtime,
  input  logic            txn_begin,
  input  logic            txn_commit,
  output logic            ts_held,
  output logic [TS_W-1:0] own_ts
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_held <= 1'b0;
      own_ts  <= '0;
    end else if (txn_commit) begin
      ts_held <= 1'b0;
    end else if (txn_begin && !ts_held) begin
      ts_held <= 1'b1;
      own_ts  <= gtime;
    end
  end
endmodule

// File: rtl/txcr_arbiter.sv
module txcr_arbiter
  import txcr_pkg::*;
#(
  parameter int TS_W    = 16,
  parameter int ID_W    = 4,
  parameter int CORE_ID = 0
) (
  input  logic            ts_held,
  input  logic [TS_W-1:0] own_ts,
  input  logic [TS_W-1:0] req_ts,
  input  logic [ID_W-1:0] req_id,
  input  logic [1:0]      policy,
  input  logic [1:0]      ctype,
  output verdict_t        verdict,
  output logic            req_older
);
  localparam logic [ID_W-1:0] OWN_ID = ID_W'(CORE_ID);

  logic [2:0] type_bits;
  logic       is_war;
  logic       yield;

  always_comb begin
    req_older = (req_ts < own_ts) || ((req_ts == own_ts) && (req_id < OWN_ID));
  end

  always_comb begin
    unique case (ctype_e'(ctype))
      CT_WAR:  type_bits = 3'b001;
      CT_RAW:  type_bits = 3'b010;
      default: type_bits = 3'b100;
    endcase
    is_war = (ctype_e'(ctype) == CT_WAR);
  end

  always_comb begin
    unique case (policy_e'(policy))
      POL_AGE:   yield = req_older;
      POL_MIXED: yield = is_war && req_older;
      default:   yield = 1'b0;
    endcase
  end

  always_comb begin
    verdict = '0;
    if (ts_held) begin
      verdict.abort = yield;
      verdict.nack  = !yield;
      if (!yield) verdict.meta = {!req_older, type_bits};
    end
  end
endmodule

// File: rtl/txcr_deadlock_watch.sv
module txcr_deadlock_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic ts_held,
  input  logic nacked_older,
  input  logic clear,
  input  logic own_req_nacked,
  input  logic own_nack_resp_older,
  output logic dl_abort
);
  logic refused_older_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            refused_older_q <= 1'b0;
    else if (clear)        refused_older_q <= 1'b0;
    else if (nacked_older) refused_older_q <= 1'b1;
  end

  always_comb begin
    dl_abort = ts_held && refused_older_q && own_req_nacked && own_nack_resp_older;
  end
endmodule

// File: rtl/txn_conflict_resolver.sv
module txn_conflict_resolver
  import txcr_pkg::*;
#(
  parameter int TS_W    = 16,
  parameter int ID_W    = 4,
  parameter int CORE_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   gtime,
  input  logic              txn_begin,
  input  logic              txn_commit,
  input  logic              conf_valid,
  output logic              conf_ready,
  input  logic [1:0]        conf_policy,
  input  logic [1:0]        conf_type,
  input  logic [TS_W-1:0]   conf_req_ts,
  input  logic [ID_W-1:0]   conf_req_id,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_nack,
  output logic              resp_abort,
  output logic [META_W-1:0] resp_meta,
  input  logic              own_req_nacked,
  input  logic              own_nack_resp_older,
  output logic              abort_req,
  output logic              stall_retry
);
  logic            ts_held;
  logic [TS_W-1:0] own_ts;
  verdict_t        verdict;
  verdict_t        resp_q;
  logic            req_older;
  logic            accept;
  logic            accept_yield;
  logic            dl_abort;
  logic            abort_now;

  txcr_ts_holder #(.TS_W(TS_W)) ts_i (
    .clk(clk), .rst_n(rst_n), .gtime(gtime),
    .txn_begin(txn_begin), .txn_commit(txn_commit),
    .ts_held(ts_held), .own_ts(own_ts)
  );

  txcr_arbiter #(.TS_W(TS_W), .ID_W(ID_W), .CORE_ID(CORE_ID)) arb_i (
    .ts_held(ts_held), .own_ts(own_ts),
    .req_ts(conf_req_ts), .req_id(conf_req_id),
    .policy(conf_policy), .ctype(conf_type),
    .verdict(verdict), .req_older(req_older)
  );

  always_comb begin
    conf_ready   = !resp_valid || resp_ready;
    accept       = conf_valid && conf_ready;
    accept_yield = accept && verdict.abort;
    abort_now    = accept_yield || dl_abort;
  end

  txcr_deadlock_watch dl_i (
    .clk(clk), .rst_n(rst_n), .ts_held(ts_held),
    .nacked_older(accept && verdict.nack && req_older),
    .clear(abort_now || txn_begin || txn_commit),
    .own_req_nacked(own_req_nacked),
    .own_nack_resp_older(own_nack_resp_older),
    .dl_abort(dl_abort)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_q      <= '0;
      abort_req   <= 1'b0;
      stall_retry <= 1'b0;
    end else begin
      if (accept) begin
        resp_valid <= 1'b1;
        resp_q     <= verdict;
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
      abort_req   <= abort_now;
      stall_retry <= own_req_nacked && !abort_now;
    end
  end

  always_comb begin
    resp_nack  = resp_q.nack;
    resp_abort = resp_q.abort;
    resp_meta  = resp_q.meta;
  end
endmodule

// File: rtl/txcr_checker.sv
module txcr_checker #(
  parameter int TS_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conf_valid,
  input logic            conf_ready,
  input logic            resp_valid,
  input logic            resp_ready,
  input logic            resp_nack,
  input logic            resp_abort,
  input logic [3:0]      resp_meta,
  input logic            abort_req,
  input logic            stall_retry,
  input logic            txn_commit,
  input logic            ts_held,
  input logic [TS_W-1:0] own_ts
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_nack)
      && $stable(resp_abort) && $stable(resp_meta));

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_nack && resp_abort));

  assert_meta_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_nack |-> resp_meta == 4'd0);

  assert_meta_type_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_nack |-> $countones(resp_meta[2:0]) == 1);

  assert_abort_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conf_valid && conf_ready |=> resp_valid && (!resp_abort || abort_req));

  assert_pulses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({abort_req, stall_retry}));

  assert_keep_ts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ts_held && !txn_commit |=> ts_held && $stable(own_ts));

  assert_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conf_valid && conf_ready && !ts_held |=> !resp_nack && !resp_abort);
endmodule

bind txn_conflict_resolver txcr_checker #(.TS_W(TS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .conf_valid(conf_valid), .conf_ready(conf_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_nack(resp_nack),
  .resp_abort(resp_abort), .resp_meta(resp_meta), .abort_req(abort_req),
  .stall_retry(stall_retry), .txn_commit(txn_commit), .ts_held(ts_held),
  .own_ts(own_ts)
);

// File: tb/txn_conflict_resolver_tb_top.sv
`timescale 1ns/1ps
module txn_conflict_resolver_tb_top;
  localparam int TS_W = 8;
  localparam int ID_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TS_W-1:0] gtime = '0;
  logic txn_begin = 1'b0, txn_commit = 1'b0;
  logic conf_valid = 1'b0, conf_ready;
  logic [1:0] conf_policy = '0, conf_type = '0;
  logic [TS_W-1:0] conf_req_ts = '0;
  logic [ID_W-1:0] conf_req_id = '0;
  logic resp_valid, resp_ready = 1'b1, resp_nack, resp_abort;
  logic [3:0] resp_meta;
  logic own_req_nacked = 1'b0, own_nack_resp_older = 1'b0;
  logic abort_req, stall_retry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  txn_conflict_resolver #(.TS_W(TS_W), .ID_W(ID_W), .CORE_ID(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .gtime(gtime), .txn_begin(txn_begin),
    .txn_commit(txn_commit), .conf_valid(conf_valid), .conf_ready(conf_ready),
    .conf_policy(conf_policy), .conf_type(conf_type), .conf_req_ts(conf_req_ts),
    .conf_req_id(conf_req_id), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_nack(resp_nack), .resp_abort(resp_abort), .resp_meta(resp_meta),
    .own_req_nacked(own_req_nacked), .own_nack_resp_older(own_nack_resp_older),
    .abort_req(abort_req), .stall_retry(stall_retry)
  );

  // {policy, type, req_ts, req_id, nack, abort, meta}; local ts 50, local id 3
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'd40, 3'd0, 1'b1, 1'b0, 4'b0001},
    {2'd0, 2'd2, 8'd60, 3'd0, 1'b1, 1'b0, 4'b1100},
    {2'd1, 2'd1, 8'd40, 3'd0, 1'b0, 1'b1, 4'b0000},
    {2'd1, 2'd2, 8'd60, 3'd0, 1'b1, 1'b0, 4'b1100},
    {2'd1, 2'd0, 8'd50, 3'd2, 1'b0, 1'b1, 4'b0000},
    {2'd1, 2'd0, 8'd50, 3'd5, 1'b1, 1'b0, 4'b1001},
    {2'd2, 2'd0, 8'd40, 3'd0, 1'b0, 1'b1, 4'b0000},
    {2'd2, 2'd0, 8'd60, 3'd0, 1'b1, 1'b0, 4'b1001},
    {2'd2, 2'd1, 8'd40, 3'd0, 1'b1, 1'b0, 4'b0010},
    {2'd2, 2'd2, 8'd40, 3'd0, 1'b1, 1'b0, 4'b0100},
    {2'd3, 2'd1, 8'd60, 3'd0, 1'b1, 1'b0, 4'b1010},
    {2'd0, 2'd3, 8'd60, 3'd0, 1'b1, 1'b0, 4'b1100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one conflict; verdict checked on the negedge after the accepting edge
  task automatic conflict(input logic [1:0] pol, input logic [1:0] ct,
                          input logic [7:0] ts, input logic [2:0] id,
                          input logic en, input logic ea, input logic [3:0] em,
                          input string req);
    @(negedge clk);
    conf_valid = 1'b1; conf_policy = pol; conf_type = ct;
    conf_req_ts = ts; conf_req_id = id; resp_ready = 1'b1;
    @(negedge clk);
    conf_valid = 1'b0;
    check({req, " valid"}, 32'(resp_valid), 32'd1);
    check({req, " nack"}, 32'(resp_nack), 32'(en));
    check({req, " abort"}, 32'(resp_abort), 32'(ea));
    check({req, " abort_req"}, 32'(abort_req), 32'(ea));
    check({req, " meta"}, 32'(resp_meta), 32'(em));
  endtask

  task automatic begin_txn(input logic [7:0] t);
    @(negedge clk); gtime = t; txn_begin = 1'b1;
    @(negedge clk); txn_begin = 1'b0;
  endtask

  task automatic commit_txn();
    @(negedge clk); txn_commit = 1'b1;
    @(negedge clk); txn_commit = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 resp_valid in reset", 32'(resp_valid), 32'd0);
    check("R1 abort_req in reset", 32'(abort_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 resp_valid after reset", 32'(resp_valid), 32'd0);
    check("R1 stall_retry after reset", 32'(stall_retry), 32'd0);
    check("R10 conf_ready idle", 32'(conf_ready), 32'd1);

    // R8: no transaction held
    conflict(2'd1, 2'd0, 8'd10, 3'd0, 1'b0, 1'b0, 4'b0000, "R8 grant");

    // table: R3 R4 R5 R6 R7 R11
    begin_txn(8'd50);
    for (int i = 0; i < NV; i++) begin
      conflict(VEC[i][20:19], VEC[i][18:17], VEC[i][16:9], VEC[i][8:6],
               VEC[i][5], VEC[i][4], VEC[i][3:0], $sformatf("R4/R5/R6/R7 vec%0d", i));
    end

    // R2: second begin does not recapture
    begin_txn(8'd90);
    conflict(2'd1, 2'd2, 8'd70, 3'd0, 1'b1, 1'b0, 4'b1100, "R2 ts kept");
    commit_txn();
    begin_txn(8'd90);
    conflict(2'd1, 2'd2, 8'd70, 3'd0, 1'b0, 1'b1, 4'b0000, "R2 ts recaptured");

    // R9: refuse older requester, then refused by older responder
    conflict(2'd0, 2'd0, 8'd20, 3'd0, 1'b1, 1'b0, 4'b0001, "R9 setup");
    @(negedge clk); own_req_nacked = 1'b1; own_nack_resp_older = 1'b1;
    @(negedge clk);
    check("R9 deadlock abort", 32'(abort_req), 32'd1);
    check("R9 no stall on abort", 32'(stall_retry), 32'd0);
    @(negedge clk);
    check("R12 cleared by abort: stall", 32'(stall_retry), 32'd1);
    check("R12 cleared by abort: no abort", 32'(abort_req), 32'd0);
    own_req_nacked = 1'b0;

    // R9: younger responder gives stall even with record set
    conflict(2'd0, 2'd1, 8'd20, 3'd0, 1'b1, 1'b0, 4'b0010, "R9 setup2");
    @(negedge clk); own_req_nacked = 1'b1; own_nack_resp_older = 1'b0;
    @(negedge clk); own_req_nacked = 1'b0;
    check("R9 younger responder stall", 32'(stall_retry), 32'd1);
    check("R9 younger responder no abort", 32'(abort_req), 32'd0);
    // R12: commit clears record
    commit_txn();
    begin_txn(8'd90);
    @(negedge clk); own_req_nacked = 1'b1; own_nack_resp_older = 1'b1;
    @(negedge clk); own_req_nacked = 1'b0;
    check("R12 cleared by commit: stall", 32'(stall_retry), 32'd1);
    check("R12 cleared by commit: no abort", 32'(abort_req), 32'd0);

    // R10: back-pressure
    @(negedge clk);
    resp_ready = 1'b0; conf_valid = 1'b1; conf_policy = 2'd0;
    conf_type = 2'd2; conf_req_ts = 8'd20; conf_req_id = 3'd0;
    @(negedge clk);
    check("R10 first held valid", 32'(resp_valid), 32'd1);
    check("R10 ready low", 32'(conf_ready), 32'd0);
    conf_type = 2'd1; conf_policy = 2'd1;
    @(negedge clk);
    check("R10 held meta", 32'(resp_meta), 32'b0100);
    check("R10 held nack", 32'(resp_nack), 32'd1);
    resp_ready = 1'b1;
    @(negedge clk);
    conf_valid = 1'b0;
    check("R10 second after drain abort", 32'(resp_abort), 32'd1);
    check("R10 second after drain meta", 32'(resp_meta), 32'd0);
    @(negedge clk);
    check("R10 drained", 32'(resp_valid), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule